// File: doc/BRIEF.md
# DMA Channel Register Interface

This block is the software-visible register file of a four-channel DMA controller, reached over an 8-bit I/O bus. For each channel it holds a starting address and a transfer count, each with a base copy and a working copy. It also holds a mask bit, a sticky end-of-transfer flag and a mode: the transfer direction, the autoinitialize option and the single-transfer option. The registers are 16 bits wide, but each channel has only one 8-bit port for its address and one for its count. A single flip-flop, shared by every channel, decides whether a byte access reaches the low half or the high half. Three command ports set or clear one channel's mask, write one channel's mode, and reset that flip-flop.

A transfer engine outside this block reports each completed transfer on a step input that names the channel. On each step the channel's working address moves forward by one and its working count moves back by one. Software loads the count as the number of transfers minus one, so terminal count is reached on the step taken while the count reads zero. At terminal count the channel either reloads its working registers from the base copies (autoinitialize) or masks itself and records the event.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every channel is masked (mask_o = 4'hF), all address and count registers read 0, dir_o, auto_o, single_o, tc_flag_o and tc_pulse_o are 0, and the byte pointer selects the low byte.
- R2: Port 2c is the address port and port 2c+1 the count port of channel c. A write loads the selected byte of both the base and the working register. A read returns the selected byte of the working register. A 16-bit value takes two accesses, low byte first.
- R3: The byte pointer is shared by all channels. It flips after every read or write to any address or count port, so a low-byte access to one channel makes the next access to another channel reach the high byte.
- R4: Any write to port 10 (clear pointer) sets the byte pointer back to the low byte, whatever the data.
- R5: A write to port 8 (single mask) selects the channel with bits 1:0. Bit 2 set masks that channel; bit 2 clear unmasks it. No other channel's mask changes.
- R6: A write to port 9 (mode) selects the channel with bits 1:0. Bit 2 sets the direction (1 = toward memory, shown on dir_o), bit 3 sets autoinitialize (auto_o) and bit 4 sets single-transfer mode (single_o).
- R7: A step on an unmasked channel whose working count is not zero adds one to its working address and subtracts one from its working count. The updated values are visible from the next cycle.
- R8: A step on a masked channel leaves that channel's address, count, mask and flags unchanged.
- R9: Without autoinitialize, a step taken while the working count is zero makes the count read 0xFFFF and adds one to the address. It also sets the channel's mask and its sticky tc_flag_o bit, and raises tc_pulse_o for that channel for exactly one cycle. A later write to the channel's count port clears tc_flag_o.
- R10: With autoinitialize, a step taken while the working count is zero reloads the working address and count from their base values and raises tc_pulse_o for one cycle. The channel stays unmasked and tc_flag_o stays clear.
- R11: A read of any port other than the address and count ports returns 0 and does not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | I/O port number |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr and the byte pointer |
| step_valid | input | 1 | One transfer completed |
| step_chan | input | 2 | Channel of the completed transfer |
| mask_o | output | 4 | Mask bit per channel |
| dir_o | output | 4 | Direction per channel (1 = toward memory) |
| auto_o | output | 4 | Autoinitialize enable per channel |
| single_o | output | 4 | Single-transfer mode per channel |
| tc_flag_o | output | 4 | Sticky terminal-count flag per channel |
| tc_pulse_o | output | 4 | One-cycle terminal-count pulse per channel |

## Verification
The hardest state to reach from the ports is the step taken while the working count sits at zero. Getting there needs the count loaded byte by byte with a correctly phased pointer, the channel unmasked, and exactly length-minus-one earlier steps. The bench sweeps transfer lengths 1 to 4 on every channel and checks address and count after each step. The final step then lands on terminal count in both the masking mode and the autoinitialize mode. Pointer sharing is tested by splitting one 16-bit access across two different channels.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [REG_W-1:0] base_addr;
        logic [REG_W-1:0] cur_addr;
        logic [REG_W-1:0] base_cnt;
        logic [REG_W-1:0] cur_cnt;
        logic             mask;
        logic             dir;
        logic             autoinit;
        logic             single;
        logic             tc_sticky;
        logic             tc_pulse;
    } chan_state_t;

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic access,
    output logic hi_o
);

    logic ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d = 1'b0;
        end else if (access) begin
            ptr_d = ~ptr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= 1'b0;
        else        ptr_q <= ptr_d;
    end

    assign hi_o = ptr_q;

    p_clear_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hi_o);

    p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !clr) |=> (hi_o != $past(hi_o)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!access && !clr) |=> $stable(hi_o));

endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              mask_wr,
    input  logic              mask_set,
    input  logic              mode_wr,
    input  logic              mode_dir,
    input  logic              mode_auto,
    input  logic              mode_single,
    input  logic              step,
    output logic [REG_W-1:0]  cur_addr_o,
    output logic [REG_W-1:0]  cur_cnt_o,
    output logic              mask_o,
    output logic              dir_o,
    output logic              auto_o,
    output logic              single_o,
    output logic              tc_flag_o,
    output logic              tc_pulse_o
);

    chan_state_t s_d, s_q;
    logic        live_step;
    logic        at_zero;
    logic        bus_touch;

    assign live_step = step && !s_q.mask;
    assign at_zero   = (s_q.cur_cnt == '0);
    assign bus_touch = wr_addr || wr_cnt || mask_wr || mode_wr;

    always_comb begin
        s_d          = s_q;
        s_d.tc_pulse = 1'b0;

        if (live_step) begin
            if (at_zero) begin
                s_d.tc_pulse = 1'b1;
                if (s_q.autoinit) begin
                    s_d.cur_addr = s_q.base_addr;
                    s_d.cur_cnt  = s_q.base_cnt;
                end else begin
                    s_d.cur_addr  = s_q.cur_addr + REG_W'(1);
                    s_d.cur_cnt   = '1;
                    s_d.mask      = 1'b1;
                    s_d.tc_sticky = 1'b1;
                end
            end else begin
                s_d.cur_addr = s_q.cur_addr + REG_W'(1);
                s_d.cur_cnt  = s_q.cur_cnt - REG_W'(1);
            end
        end

        if (wr_addr) begin
            if (sel_hi) begin
                s_d.base_addr[REG_W-1:BYTE_W] = wdata;
                s_d.cur_addr[REG_W-1:BYTE_W]  = wdata;
            end else begin
                s_d.base_addr[BYTE_W-1:0] = wdata;
                s_d.cur_addr[BYTE_W-1:0]  = wdata;
            end
        end

        if (wr_cnt) begin
            s_d.tc_sticky = 1'b0;
            if (sel_hi) begin
                s_d.base_cnt[REG_W-1:BYTE_W] = wdata;
                s_d.cur_cnt[REG_W-1:BYTE_W]  = wdata;
            end else begin
                s_d.base_cnt[BYTE_W-1:0] = wdata;
                s_d.cur_cnt[BYTE_W-1:0]  = wdata;
            end
        end

        if (mask_wr) begin
            s_d.mask = mask_set;
        end

        if (mode_wr) begin
            s_d.dir      = mode_dir;
            s_d.autoinit = mode_auto;
            s_d.single   = mode_single;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_addr_o = s_q.cur_addr;
    assign cur_cnt_o  = s_q.cur_cnt;
    assign mask_o     = s_q.mask;
    assign dir_o      = s_q.dir;
    assign auto_o     = s_q.autoinit;
    assign single_o   = s_q.single;
    assign tc_flag_o  = s_q.tc_sticky;
    assign tc_pulse_o = s_q.tc_pulse;

    p_step_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !mask_o && cur_cnt_o != '0 && !bus_touch)
        |=> (cur_cnt_o == $past(cur_cnt_o) - REG_W'(1))
            && (cur_addr_o == $past(cur_addr_o) + REG_W'(1)));

    p_masked_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mask_o && !bus_touch)
        |=> $stable(cur_addr_o) && $stable(cur_cnt_o) && mask_o && !tc_pulse_o);

    p_tc_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !mask_o && cur_cnt_o == '0 && !auto_o && !bus_touch)
        |=> mask_o && tc_flag_o && tc_pulse_o && (cur_cnt_o == '1));

    p_autoinit_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !mask_o && cur_cnt_o == '0 && auto_o && !bus_touch)
        |=> !mask_o && tc_pulse_o && (cur_cnt_o == $past(s_q.base_cnt))
            && (cur_addr_o == $past(s_q.base_addr)));

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse_o |=> !tc_pulse_o || $past(step));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [BYTE_W-1:0]         bus_wdata,
    output logic [BYTE_W-1:0]         bus_rdata,
    input  logic                      step_valid,
    input  logic [$clog2(NUM_CH)-1:0] step_chan,
    output logic [NUM_CH-1:0]         mask_o,
    output logic [NUM_CH-1:0]         dir_o,
    output logic [NUM_CH-1:0]         auto_o,
    output logic [NUM_CH-1:0]         single_o,
    output logic [NUM_CH-1:0]         tc_flag_o,
    output logic [NUM_CH-1:0]         tc_pulse_o
);

    localparam int CH_W     = $clog2(NUM_CH);
    localparam int REG_PORTS = 2 * NUM_CH;
    localparam int P_MASK   = REG_PORTS;
    localparam int P_MODE   = REG_PORTS + 1;
    localparam int P_CLR    = REG_PORTS + 2;
    localparam int B_FLAG   = CH_W;
    localparam int B_DIR    = CH_W;
    localparam int B_AUTO   = CH_W + 1;
    localparam int B_SINGLE = CH_W + 2;

    logic              reg_port;
    logic [CH_W-1:0]   port_ch;
    logic              port_is_cnt;
    logic              ptr_hi;
    logic              ptr_clr;
    logic              ptr_access;
    logic              mask_wr_any;
    logic              mode_wr_any;
    logic [CH_W-1:0]   cmd_ch;
    logic              unused_wdata;

    logic [REG_W-1:0]  cur_addr_v [NUM_CH];
    logic [REG_W-1:0]  cur_cnt_v  [NUM_CH];

    assign reg_port    = (int'(bus_addr) < REG_PORTS);
    assign port_ch     = bus_addr[CH_W:1];
    assign port_is_cnt = bus_addr[0];
    assign ptr_clr     = bus_wr && (int'(bus_addr) == P_CLR);
    assign ptr_access  = (bus_wr || bus_rd) && reg_port;
    assign mask_wr_any = bus_wr && (int'(bus_addr) == P_MASK);
    assign mode_wr_any = bus_wr && (int'(bus_addr) == P_MODE);
    assign cmd_ch      = bus_wdata[CH_W-1:0];
    assign unused_wdata = ^bus_wdata[BYTE_W-1:B_SINGLE+1];

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ptr_clr),
        .access (ptr_access),
        .hi_o   (ptr_hi)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic this_reg;
        assign this_reg = bus_wr && reg_port && (port_ch == CH_W'(i));

        dma_chan_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel_hi      (ptr_hi),
            .wdata       (bus_wdata),
            .wr_addr     (this_reg && !port_is_cnt),
            .wr_cnt      (this_reg && port_is_cnt),
            .mask_wr     (mask_wr_any && (cmd_ch == CH_W'(i))),
            .mask_set    (bus_wdata[B_FLAG]),
            .mode_wr     (mode_wr_any && (cmd_ch == CH_W'(i))),
            .mode_dir    (bus_wdata[B_DIR]),
            .mode_auto   (bus_wdata[B_AUTO]),
            .mode_single (bus_wdata[B_SINGLE]),
            .step        (step_valid && (step_chan == CH_W'(i))),
            .cur_addr_o  (cur_addr_v[i]),
            .cur_cnt_o   (cur_cnt_v[i]),
            .mask_o      (mask_o[i]),
            .dir_o       (dir_o[i]),
            .auto_o      (auto_o[i]),
            .single_o    (single_o[i]),
            .tc_flag_o   (tc_flag_o[i]),
            .tc_pulse_o  (tc_pulse_o[i])
        );
    end

    always_comb begin
        logic [REG_W-1:0] word;
        word      = port_is_cnt ? cur_cnt_v[port_ch] : cur_addr_v[port_ch];
        bus_rdata = '0;
        if (bus_rd && reg_port) begin
            bus_rdata = ptr_hi ? word[REG_W-1:BYTE_W] : word[BYTE_W-1:0];
        end
    end

    p_idle_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !reg_port) |-> (bus_rdata == '0));

    p_mask_one_ch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_any && !step_valid)
        |=> ($countones(mask_o ^ $past(mask_o)) <= 1));

endmodule

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       step_valid = 1'b0;
    logic [1:0] step_chan = '0;
    logic [3:0] mask_o, dir_o, auto_o, single_o, tc_flag_o, tc_pulse_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_chan_regs u_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .step_valid(step_valid), .step_chan(step_chan), .mask_o(mask_o),
        .dir_o(dir_o), .auto_o(auto_o), .single_o(single_o),
        .tc_flag_o(tc_flag_o), .tc_pulse_o(tc_pulse_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic load16(input logic [3:0] a, input logic [15:0] v);
        wr(4'd10, 8'h5A);
        wr(a, v[7:0]);
        wr(a, v[15:8]);
    endtask

    task automatic read16(input logic [3:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        wr(4'd10, 8'h00);
        rd(a, lo);
        rd(a, hi);
        v = {hi, lo};
    endtask

    // pulse sampled at the negedge following the capturing posedge
    task automatic step(input logic [1:0] c, output logic [3:0] pulse);
        @(negedge clk);
        step_chan = c; step_valid = 1'b1;
        @(negedge clk);
        step_valid = 1'b0;
        pulse = tc_pulse_o;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        logic [3:0]  p;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 mask", {28'd0, mask_o}, 32'hF);
        chk("R1 flags", {16'd0, dir_o, auto_o, single_o, tc_flag_o}, 32'h0);
        chk("R1 pulse", {28'd0, tc_pulse_o}, 32'h0);
        for (int port = 0; port < 8; port++) begin
            read16(4'(port), v);
            chk("R1 regs", {16'd0, v}, 32'h0);
        end

        // R2 write/read sweep on every channel
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] av, cv;
                av = 16'(c * 16'h1111 + k * 16'h0F37 + 1);
                cv = av ^ 16'hA5C3;
                load16(4'(2*c), av);
                load16(4'(2*c+1), cv);
                read16(4'(2*c), v);
                chk("R2 address", {16'd0, v}, {16'd0, av});
                read16(4'(2*c+1), v);
                chk("R2 count", {16'd0, v}, {16'd0, cv});
            end
        end

        // R3 shared pointer: low write to ch0 address, then read ch1 count hits high byte
        load16(4'd3, 16'hBEEF);
        wr(4'd10, 8'h00);
        wr(4'd0, 8'h12);
        rd(4'd3, b);
        chk("R3 shared pointer", {24'd0, b}, 32'hBE);
        rd(4'd3, b);
        chk("R3 toggles back", {24'd0, b}, 32'hEF);

        // R4 clear mid-word, any data
        load16(4'd4, 16'h7788);
        wr(4'd10, 8'hFF);
        rd(4'd4, b);
        wr(4'd10, 8'h3C);
        rd(4'd4, b);
        chk("R4 clear gives low", {24'd0, b}, 32'h88);

        // R11 read of command port returns 0 and leaves pointer
        wr(4'd10, 8'h00);
        rd(4'd9, b);
        chk("R11 read zero", {24'd0, b}, 32'h0);
        rd(4'd4, b);
        chk("R11 pointer unmoved", {24'd0, b}, 32'h88);

        // R5 single mask
        for (int c = 0; c < 4; c++) begin
            wr(4'd8, 8'(c));
            chk("R5 unmask", {28'd0, mask_o}, 32'(4'hF & ~(4'(1) << c)));
            wr(4'd8, 8'(c | 4));
            chk("R5 remask", {28'd0, mask_o}, 32'hF);
        end

        // R6 mode fields
        for (int c = 0; c < 4; c++) begin
            wr(4'd9, 8'(c | 8'h04 | 8'h10));
            chk("R6 dir", {31'd0, dir_o[c]}, 32'd1);
            chk("R6 single", {31'd0, single_o[c]}, 32'd1);
            chk("R6 auto off", {31'd0, auto_o[c]}, 32'd0);
            wr(4'd9, 8'(c | 8'h08));
            chk("R6 auto", {28'd0, auto_o}, 32'(4'(1) << c));
            chk("R6 dir cleared", {31'd0, dir_o[c]}, 32'd0);
            wr(4'd9, 8'(c));
        end

        // R7 R8 R9: non-autoinit length sweep
        for (int c = 0; c < 4; c++) begin
            for (int n = 1; n <= 4; n++) begin
                logic [15:0] a0;
                a0 = 16'(16'h10F0 * (c + 1) + n * 16'h0107);
                if (c == 2 && n == 4) a0 = 16'hFFFE;
                load16(4'(2*c), a0);
                load16(4'(2*c+1), 16'(n - 1));
                wr(4'd8, 8'(c));
                for (int k = 1; k < n; k++) begin
                    step(2'(c), p);
                    chk("R7 no pulse", {28'd0, p}, 32'd0);
                    read16(4'(2*c), v);
                    chk("R7 address", {16'd0, v}, {16'd0, 16'(a0 + k)});
                    read16(4'(2*c+1), v);
                    chk("R7 count", {16'd0, v}, 32'(n - 1 - k));
                end
                step(2'(c), p);
                chk("R9 pulse", {28'd0, p}, 32'(4'(1) << c));
                @(negedge clk);
                chk("R9 pulse one cycle", {28'd0, tc_pulse_o}, 32'd0);
                chk("R9 masked", {31'd0, mask_o[c]}, 32'd1);
                chk("R9 sticky", {28'd0, tc_flag_o}, 32'(4'(1) << c));
                read16(4'(2*c+1), v);
                chk("R9 count FFFF", {16'd0, v}, 32'hFFFF);
                read16(4'(2*c), v);
                chk("R9 address", {16'd0, v}, {16'd0, 16'(a0 + n)});
                step(2'(c), p);
                chk("R8 no pulse", {28'd0, p}, 32'd0);
                read16(4'(2*c), v);
                chk("R8 address held", {16'd0, v}, {16'd0, 16'(a0 + n)});
                read16(4'(2*c+1), v);
                chk("R8 count held", {16'd0, v}, 32'hFFFF);
                chk("R8 sticky held", {31'd0, tc_flag_o[c]}, 32'd1);
                wr(4'd10, 8'h00);
                wr(4'(2*c+1), 8'h00);
                chk("R9 sticky cleared", {31'd0, tc_flag_o[c]}, 32'd0);
            end
        end

        // R10 autoinitialize
        for (int c = 0; c < 4; c++) begin
            logic [15:0] a0;
            a0 = 16'(16'h2200 + c * 16'h0333);
            wr(4'd9, 8'(c | 8'h08));
            load16(4'(2*c), a0);
            load16(4'(2*c+1), 16'd2);
            wr(4'd8, 8'(c));
            step(2'(c), p);
            step(2'(c), p);
            step(2'(c), p);
            chk("R10 pulse", {28'd0, p}, 32'(4'(1) << c));
            chk("R10 unmasked", {31'd0, mask_o[c]}, 32'd0);
            chk("R10 no sticky", {31'd0, tc_flag_o[c]}, 32'd0);
            read16(4'(2*c), v);
            chk("R10 address reload", {16'd0, v}, {16'd0, a0});
            read16(4'(2*c+1), v);
            chk("R10 count reload", {16'd0, v}, 32'd2);
            step(2'(c), p);
            read16(4'(2*c+1), v);
            chk("R10 counts again", {16'd0, v}, 32'd1);
            wr(4'd8, 8'(c | 4));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule